// File: doc/BRIEF.md
# Trap Cause and Delegation Unit

This unit decides how a RISC-V hart enters and leaves a trap. Each cycle it looks at the synchronous exception requests raised by the pipeline, the pending interrupt lines, the per-interrupt enable mask and the current privilege level. It picks at most one trap, forms the XLEN-wide cause value, and chooses whether the machine handler or the supervisor handler receives it. The choice uses two separate delegation masks, one for exceptions and one for interrupts. On entry it records the cause and faulting PC in the target level's cause and epc registers, pushes the privilege and interrupt-enable bits onto the status stack, and redirects fetch to that level's trap vector.

The unit also executes the two trap-return operations. Machine return restores privilege from the saved machine-previous-privilege field. Supervisor return restores it from the saved supervisor-previous-privilege bit. Both re-enable interrupts from the saved copy and redirect fetch to the saved epc. A plain write port loads the status word, so that software state such as the global interrupt enables and a prepared return privilege can be set up.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the privilege is M (encoding 2'b11), the status word reads zero, both cause registers read zero and no redirect is signalled.
- R2: Exception request bits map to cause codes as follows: bit0 illegal instruction = 2, bit1 breakpoint = 3, bit2 environment call = 8 from U, 9 from S and 11 from M, bit3 misaligned load = 4, bit4 misaligned store = 6. The cause MSB is 0 for exceptions.
- R3: An interrupt cause has bit XLEN-1 set and the interrupt number in its low bits. Pending line n is interrupt number n: 1 S software, 3 M software, 5 S timer, 7 M timer, 9 S external, 11 M external.
- R4: An exception raised in U or S goes to S when its medeleg bit (indexed by cause code) is set, and to M otherwise. A trap raised in M always goes to M.
- R5: An interrupt is routed the same way, using the mideleg bit of its interrupt number.
- R6: A pending interrupt needs its enable-mask bit. If it is routed to M, it is taken in U and S, and in M only when status bit 3 (MIE) is set. If it is routed to S, it is taken in U, in S only when status bit 1 (SIE) is set, and never in M.
- R7: A takeable interrupt wins over any exception. Among exceptions the lowest request bit wins. Among interrupts the order is 11, 9, 3, 1, 7, 5.
- R8: On trap entry at a rising edge, the target's cause register gets the cause and its epc gets the PC. The privilege becomes the target level. The target's previous-enable bit (MPIE bit 7 / SPIE bit 5) takes the enable bit, which then clears. The previous-privilege field (MPP bits 12:11 / SPP bit 8) takes the old privilege. A one-cycle redirect carries mtvec or stvec.
- R9: Machine return in M sets the privilege to MPP, MIE to MPIE, MPIE to 1 and MPP to U, and redirects to mepc. Outside M it has no effect.
- R10: Supervisor return in S or M sets the privilege to S if SPP is 1 and to U otherwise, SIE to SPIE, SPIE to 1 and SPP to 0, and redirects to sepc. In U it has no effect.
- R11: The status write port loads bits 1, 3, 5, 7, 8 and 12:11. An MPP value of 2'b10 is stored as U. A trap or return in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | XLEN | PC of the instruction being trapped |
| exc_req_i | input | 5 | Exception requests, bit order per R2 |
| irq_pend_i | input | IRQW | Pending interrupt lines, indexed by interrupt number |
| irq_en_i | input | IRQW | Per-interrupt enable mask |
| irq_deleg_i | input | IRQW | Interrupt delegation mask |
| exc_deleg_i | input | EXCW | Exception delegation mask, indexed by cause code |
| mtvec_i | input | XLEN | Machine trap vector |
| stvec_i | input | XLEN | Supervisor trap vector |
| mret_i | input | 1 | Machine return request |
| sret_i | input | 1 | Supervisor return request |
| status_we_i | input | 1 | Status write strobe |
| status_wdata_i | input | XLEN | Status write data |
| priv_o | output | 2 | Current privilege |
| status_o | output | XLEN | Status word |
| mcause_o | output | XLEN | Machine cause register |
| scause_o | output | XLEN | Supervisor cause register |
| mepc_o | output | XLEN | Machine epc |
| sepc_o | output | XLEN | Supervisor epc |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | XLEN | Redirect target |

## Verification
Each exception is raised from M, S and U under all-set and all-clear delegation masks. This separates the fixed code table, the privilege-dependent call code and the rule that M never delegates. Several requests are raised together, exception pairs and then interrupt mixes, to show the priority order and that interrupts beat exceptions. Interrupts are also offered while the gating bits are clear, to show they are held off. After every return the redirect target and privilege show whether the saved previous-privilege fields were pushed and popped correctly.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned NEXC   = 5;
  localparam int unsigned NRANK  = 6;
  localparam int unsigned CODEW  = 4;

  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPPL = 11;
  localparam int unsigned ST_MPPH = 12;

  // cause code of exception request bit idx
  function automatic logic [CODEW-1:0] exc_code(input int idx, input priv_e p);
    case (idx)
      0:       return 4'd2;
      1:       return 4'd3;
      2:       return 4'd8 + {2'b00, p};
      3:       return 4'd4;
      default: return 4'd6;
    endcase
  endfunction

  // interrupt number at priority rank r (0 = highest)
  function automatic int unsigned irq_rank_code(input int r);
    case (r)
      0:       return 11;
      1:       return 9;
      2:       return 3;
      3:       return 1;
      4:       return 7;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/trap_irq_gate.sv
module trap_irq_gate
  import trap_pkg::*;
#(
  parameter int unsigned IRQW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  priv_e           priv_i,
  input  logic            st_mie_i,
  input  logic            st_sie_i,
  input  logic [IRQW-1:0] pend_i,
  input  logic [IRQW-1:0] en_i,
  input  logic [IRQW-1:0] deleg_i,
  output logic [IRQW-1:0] ok_o
);

  logic m_en;
  logic s_en;

  assign m_en = (priv_i != PRIV_M) || st_mie_i;
  assign s_en = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && st_sie_i);

  for (genvar g = 0; g < IRQW; g++) begin : g_line
    assign ok_o[g] = pend_i[g] && en_i[g] && (deleg_i[g] ? s_en : m_en);
  end

  AST_NO_SIRQ_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_M) |-> ((ok_o & deleg_i) == '0)); // R6
  AST_MIRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv_i == PRIV_M) && !st_mie_i) |-> (ok_o == '0)); // R6

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IRQW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  priv_e            priv_i,
  input  logic [NEXC-1:0]  exc_req_i,
  input  logic [IRQW-1:0]  irq_ok_i,
  output logic             valid_o,
  output logic             is_irq_o,
  output logic [CODEW-1:0] code_o,
  output logic [XLEN-1:0]  cause_o
);

  localparam int unsigned PADW = XLEN - 1 - CODEW;

  logic             exc_hit;
  logic             irq_hit;
  logic [CODEW-1:0] ecode;
  logic [CODEW-1:0] icode;
  logic             unused_irq;

  assign unused_irq = ^irq_ok_i;

  always_comb begin
    exc_hit = 1'b0;
    ecode   = '0;
    for (int i = NEXC - 1; i >= 0; i--) begin
      if (exc_req_i[i]) begin
        exc_hit = 1'b1;
        ecode   = exc_code(i, priv_i);
      end
    end
    irq_hit = 1'b0;
    icode   = '0;
    for (int r = NRANK - 1; r >= 0; r--) begin
      if (irq_ok_i[irq_rank_code(r)]) begin
        irq_hit = 1'b1;
        icode   = CODEW'(irq_rank_code(r));
      end
    end
  end

  assign valid_o  = exc_hit || irq_hit;
  assign is_irq_o = irq_hit;
  assign code_o   = irq_hit ? icode : ecode;
  assign cause_o  = {irq_hit, {PADW{1'b0}}, code_o};

  AST_IRQ_BEATS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ok_i[11] || irq_ok_i[7]) && (exc_req_i != '0)) |-> (cause_o[XLEN-1] && valid_o)); // R7
  AST_ILLEGAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ok_i == '0) && exc_req_i[0]) |-> (cause_o == XLEN'(2))); // R7

endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned IRQW = 16,
  parameter int unsigned EXCW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  priv_e            priv_i,
  input  logic             valid_i,
  input  logic             is_irq_i,
  input  logic [CODEW-1:0] code_i,
  input  logic [EXCW-1:0]  exc_deleg_i,
  input  logic [IRQW-1:0]  irq_deleg_i,
  output logic             to_s_o
);

  logic deleg_bit;

  assign deleg_bit = is_irq_i ? irq_deleg_i[code_i] : exc_deleg_i[code_i];
  assign to_s_o    = valid_i && (priv_i != PRIV_M) && deleg_bit;

  AST_NO_DELEG_FROM_M: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (priv_i == PRIV_M)) |-> !to_s_o); // R4

endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            to_s_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic            mret_i,
  input  logic            sret_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output priv_e           priv_o,
  output logic            st_mie_o,
  output logic            st_sie_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] sepc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);

  priv_e           priv_q, priv_d, mpp_q, mpp_d;
  logic            mie_q, mie_d, sie_q, sie_d;
  logic            mpie_q, mpie_d, spie_q, spie_d;
  logic            spp_q, spp_d;
  logic [XLEN-1:0] mcause_q, mcause_d, scause_q, scause_d;
  logic [XLEN-1:0] mepc_q, mepc_d, sepc_q, sepc_d;
  logic [XLEN-1:0] rpc_q, rpc_d;
  logic            redir_q;
  logic            mret_fire, sret_fire, st_en;
  logic            unused_wd;

  assign mret_fire = mret_i && !trap_i && (priv_q == PRIV_M);
  assign sret_fire = sret_i && !trap_i && !mret_fire && (priv_q != PRIV_U);
  assign st_en     = trap_i || mret_fire || sret_fire || we_i;
  assign unused_wd = ^{wdata_i[XLEN-1:13], wdata_i[10:9], wdata_i[6],
                       wdata_i[4], wdata_i[2], wdata_i[0]};

  always_comb begin
    priv_d   = priv_q;
    mpp_d    = mpp_q;
    mie_d    = mie_q;
    sie_d    = sie_q;
    mpie_d   = mpie_q;
    spie_d   = spie_q;
    spp_d    = spp_q;
    mcause_d = mcause_q;
    scause_d = scause_q;
    mepc_d   = mepc_q;
    sepc_d   = sepc_q;
    rpc_d    = rpc_q;
    if (trap_i) begin
      if (to_s_i) begin
        scause_d = cause_i;
        sepc_d   = pc_i;
        spp_d    = (priv_q != PRIV_U);
        spie_d   = sie_q;
        sie_d    = 1'b0;
        priv_d   = PRIV_S;
        rpc_d    = stvec_i;
      end else begin
        mcause_d = cause_i;
        mepc_d   = pc_i;
        mpp_d    = priv_q;
        mpie_d   = mie_q;
        mie_d    = 1'b0;
        priv_d   = PRIV_M;
        rpc_d    = mtvec_i;
      end
    end else if (mret_fire) begin
      priv_d = mpp_q;
      mie_d  = mpie_q;
      mpie_d = 1'b1;
      mpp_d  = PRIV_U;
      rpc_d  = mepc_q;
    end else if (sret_fire) begin
      priv_d = spp_q ? PRIV_S : PRIV_U;
      sie_d  = spie_q;
      spie_d = 1'b1;
      spp_d  = 1'b0;
      rpc_d  = sepc_q;
    end else if (we_i) begin
      sie_d  = wdata_i[ST_SIE];
      mie_d  = wdata_i[ST_MIE];
      spie_d = wdata_i[ST_SPIE];
      mpie_d = wdata_i[ST_MPIE];
      spp_d  = wdata_i[ST_SPP];
      mpp_d  = (wdata_i[ST_MPPH:ST_MPPL] == 2'b10) ? PRIV_U
                                                   : priv_e'(wdata_i[ST_MPPH:ST_MPPL]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q   <= PRIV_M;
      mpp_q    <= PRIV_U;
      mie_q    <= 1'b0;
      sie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      spie_q   <= 1'b0;
      spp_q    <= 1'b0;
      mcause_q <= '0;
      scause_q <= '0;
      mepc_q   <= '0;
      sepc_q   <= '0;
      rpc_q    <= '0;
      redir_q  <= 1'b0;
    end else begin
      redir_q <= trap_i || mret_fire || sret_fire;
      if (st_en) begin
        priv_q   <= priv_d;
        mpp_q    <= mpp_d;
        mie_q    <= mie_d;
        sie_q    <= sie_d;
        mpie_q   <= mpie_d;
        spie_q   <= spie_d;
        spp_q    <= spp_d;
        mcause_q <= mcause_d;
        scause_q <= scause_d;
        mepc_q   <= mepc_d;
        sepc_q   <= sepc_d;
        rpc_q    <= rpc_d;
      end
    end
  end

  always_comb begin
    status_o                  = '0;
    status_o[ST_SIE]          = sie_q;
    status_o[ST_MIE]          = mie_q;
    status_o[ST_SPIE]         = spie_q;
    status_o[ST_MPIE]         = mpie_q;
    status_o[ST_SPP]          = spp_q;
    status_o[ST_MPPH:ST_MPPL] = mpp_q;
  end

  assign priv_o        = priv_q;
  assign st_mie_o      = mie_q;
  assign st_sie_o      = sie_q;
  assign mcause_o      = mcause_q;
  assign scause_o      = scause_q;
  assign mepc_o        = mepc_q;
  assign sepc_o        = sepc_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;

  AST_M_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !to_s_i) |=> (!mie_q && (priv_q == PRIV_M) && (mepc_q == $past(pc_i)))); // R8
  AST_S_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && to_s_i) |=> (!sie_q && (priv_q == PRIV_S) && (sepc_q == $past(pc_i)))); // R8
  AST_MRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !trap_i && (priv_q == PRIV_M)) |=> ((priv_q == $past(mpp_q)) && (mpp_q == PRIV_U))); // R9
  AST_MRET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !sret_i && !trap_i && (priv_q != PRIV_M)) |=> (priv_q == $past(priv_q))); // R9
  AST_SRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_i && !mret_i && !trap_i && (priv_q != PRIV_U)) |=> ((priv_q != PRIV_M) && !spp_q)); // R10

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IRQW = 16,
  parameter int unsigned EXCW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic [4:0]      exc_req_i,
  input  logic [IRQW-1:0] irq_pend_i,
  input  logic [IRQW-1:0] irq_en_i,
  input  logic [IRQW-1:0] irq_deleg_i,
  input  logic [EXCW-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic            mret_i,
  input  logic            sret_i,
  input  logic            status_we_i,
  input  logic [XLEN-1:0] status_wdata_i,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] sepc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);

  priv_e            priv_w;
  logic             st_mie_w, st_sie_w;
  logic [IRQW-1:0]  irq_ok_w;
  logic             valid_w, is_irq_w, to_s_w;
  logic [CODEW-1:0] code_w;
  logic [XLEN-1:0]  cause_w;

  trap_irq_gate #(.IRQW(IRQW)) gate_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_w),
    .st_mie_i(st_mie_w), .st_sie_i(st_sie_w),
    .pend_i(irq_pend_i), .en_i(irq_en_i), .deleg_i(irq_deleg_i),
    .ok_o(irq_ok_w)
  );

  trap_arbiter #(.XLEN(XLEN), .IRQW(IRQW)) arb_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_w),
    .exc_req_i(exc_req_i), .irq_ok_i(irq_ok_w),
    .valid_o(valid_w), .is_irq_o(is_irq_w), .code_o(code_w), .cause_o(cause_w)
  );

  trap_route #(.IRQW(IRQW), .EXCW(EXCW)) route_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_w),
    .valid_i(valid_w), .is_irq_i(is_irq_w), .code_i(code_w),
    .exc_deleg_i(exc_deleg_i), .irq_deleg_i(irq_deleg_i),
    .to_s_o(to_s_w)
  );

  trap_state #(.XLEN(XLEN)) state_i (
    .clk(clk), .rst_n(rst_n),
    .trap_i(valid_w), .to_s_i(to_s_w), .cause_i(cause_w), .pc_i(pc_i),
    .mtvec_i(mtvec_i), .stvec_i(stvec_i),
    .mret_i(mret_i), .sret_i(sret_i),
    .we_i(status_we_i), .wdata_i(status_wdata_i),
    .priv_o(priv_w), .st_mie_o(st_mie_w), .st_sie_o(st_sie_w),
    .status_o(status_o), .mcause_o(mcause_o), .scause_o(scause_o),
    .mepc_o(mepc_o), .sepc_o(sepc_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  assign priv_o = priv_w;

endmodule

// File: tb/trap_ctrl_tb_top.sv
`timescale 1ns/1ps
module trap_ctrl_tb_top;

  localparam int unsigned XLEN = 32;
  localparam logic [31:0] MTV = 32'h0000_0100;
  localparam logic [31:0] STV = 32'h0000_0200;
  localparam logic [1:0]  PU = 2'b00, PS = 2'b01, PM = 2'b11;
  localparam logic [31:0] IB = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [4:0]  exc_req_i = '0;
  logic [15:0] irq_pend_i = '0;
  logic [15:0] irq_en_i = 16'hFFFF;
  logic [15:0] irq_deleg_i = 16'hFFFF;
  logic [15:0] exc_deleg_i = 16'hFFFF;
  logic        mret_i = 1'b0, sret_i = 1'b0;
  logic        status_we_i = 1'b0;
  logic [31:0] status_wdata_i = '0;
  logic [1:0]  priv_o;
  logic [31:0] status_o, mcause_o, scause_o, mepc_o, sepc_o, redirect_pc_o;
  logic        redirect_o;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic [1:0]  priv;
    logic [31:0] pc;
    bit          is_trap;
    bit          is_s;
    logic [31:0] cause;
    logic [31:0] epc;
    logic [31:0] mask;
    logic [31:0] stat;
    string       tag;
  } item_t;

  item_t exp_q[$];

  always #4 clk = ~clk;

  trap_ctrl #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .exc_req_i(exc_req_i),
    .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i), .irq_deleg_i(irq_deleg_i),
    .exc_deleg_i(exc_deleg_i), .mtvec_i(MTV), .stvec_i(STV),
    .mret_i(mret_i), .sret_i(sret_i), .status_we_i(status_we_i),
    .status_wdata_i(status_wdata_i), .priv_o(priv_o), .status_o(status_o),
    .mcause_o(mcause_o), .scause_o(scause_o), .mepc_o(mepc_o), .sepc_o(sepc_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected item per redirect
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && redirect_o) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected redirect", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check({it.tag, " priv"}, {30'd0, priv_o}, {30'd0, it.priv});
          check({it.tag, " target pc"}, redirect_pc_o, it.pc);
          check({it.tag, " status"}, status_o & it.mask, it.stat);
          if (it.is_trap) begin
            check({it.tag, " cause"}, it.is_s ? scause_o : mcause_o, it.cause);
            check({it.tag, " epc"}, it.is_s ? sepc_o : mepc_o, it.epc);
          end
        end
      end
    end
  end

  task automatic trap(input logic [4:0] exc, input logic [15:0] irq, input logic [31:0] pc,
                      input logic [1:0] epriv, input bit to_s, input logic [31:0] ecause,
                      input logic [31:0] msk, input logic [31:0] sval, input string tag);
    item_t it;
    it.priv = epriv; it.pc = to_s ? STV : MTV; it.is_trap = 1'b1; it.is_s = to_s;
    it.cause = ecause; it.epc = pc; it.mask = msk; it.stat = sval; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    exc_req_i = exc; irq_pend_i = irq; pc_i = pc;
    @(negedge clk);
    exc_req_i = '0; irq_pend_i = '0;
  endtask

  task automatic ret(input bit is_m, input logic [1:0] epriv, input logic [31:0] epc,
                     input logic [31:0] msk, input logic [31:0] sval, input string tag);
    item_t it;
    it.priv = epriv; it.pc = epc; it.is_trap = 1'b0; it.is_s = 1'b0;
    it.cause = '0; it.epc = '0; it.mask = msk; it.stat = sval; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    mret_i = is_m; sret_i = !is_m;
    @(negedge clk);
    mret_i = 1'b0; sret_i = 1'b0;
  endtask

  task automatic wr_status(input logic [31:0] d, input logic [31:0] exp, input string tag);
    @(negedge clk);
    status_we_i = 1'b1; status_wdata_i = d;
    @(negedge clk);
    status_we_i = 1'b0;
    check(tag, status_o, exp);
  endtask

  task automatic idle(input logic [15:0] irq, input bit m, input bit s,
                      input logic [1:0] epriv, input logic [31:0] emc, input string tag);
    @(negedge clk);
    irq_pend_i = irq; mret_i = m; sret_i = s;
    @(negedge clk);
    irq_pend_i = '0; mret_i = 1'b0; sret_i = 1'b0;
    check({tag, " no redirect"}, {31'd0, redirect_o}, 32'd0);
    check({tag, " priv kept"}, {30'd0, priv_o}, {30'd0, epriv});
    check({tag, " mcause kept"}, mcause_o, emc);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset priv", {30'd0, priv_o}, {30'd0, PM});
    check("R1 reset status", status_o, 32'd0);
    check("R1 reset mcause", mcause_o, 32'd0);
    check("R1 reset scause", scause_o, 32'd0);
    check("R1 reset redirect", {31'd0, redirect_o}, 32'd0);

    // in M, all delegation set: nothing is delegated
    trap(5'b00001, '0, 32'h1000, PM, 0, 32'd2, 32'h1888, 32'h1800, "R2 R4 illegal from M");
    ret(1, PM, 32'h1000, 32'h1888, 32'h0080, "R9 mret to M");
    trap(5'b00100, '0, 32'h1100, PM, 0, 32'd11, 32'h1800, 32'h1800, "R2 R4 ecall from M");
    ret(1, PM, 32'h1100, 32'h1800, 32'h0000, "R9 mret to M again");
    wr_status(32'h0000_0800, 32'h0000_0800, "R11 write MPP=S");
    ret(1, PS, 32'h1100, 32'h1888, 32'h0080, "R9 mret to S");

    exc_deleg_i = '0;
    trap(5'b00010, '0, 32'h2000, PM, 0, 32'd3, 32'h1888, 32'h0800, "R2 R4 breakpoint S undelegated");
    ret(1, PS, 32'h2000, 32'h1800, 32'h0000, "R9 mret back to S");

    exc_deleg_i = 16'hFFFF;
    trap(5'b00100, '0, 32'h3000, PS, 1, 32'd9, 32'h0122, 32'h0100, "R2 R4 R8 ecall from S delegated");
    ret(0, PS, 32'h3000, 32'h0122, 32'h0020, "R10 sret to S");
    trap(5'b11000, '0, 32'h3100, PS, 1, 32'd4, 32'h0100, 32'h0100, "R7 load beats store");
    ret(0, PS, 32'h3100, 32'h0100, 32'h0000, "R10 sret to S again");
    trap(5'b01010, '0, 32'h3200, PS, 1, 32'd3, 32'h0100, 32'h0100, "R7 breakpoint beats load");
    ret(0, PS, 32'h3200, 32'h0100, 32'h0000, "R10 sret keeps S");
    ret(0, PU, 32'h3200, 32'h0100, 32'h0000, "R10 sret to U when SPP clear");

    exc_deleg_i = '0;
    trap(5'b00100, '0, 32'h4000, PM, 0, 32'd8, 32'h1800, 32'h0000, "R2 R4 ecall from U");
    ret(1, PU, 32'h4000, 32'h1800, 32'h0000, "R9 mret to U");
    exc_deleg_i = 16'hFFFF;
    trap(5'b10000, '0, 32'h4100, PS, 1, 32'd6, 32'h0100, 32'h0000, "R2 R4 store misaligned from U");
    ret(0, PU, 32'h4100, 32'h0100, 32'h0000, "R10 sret to U");

    exc_deleg_i = '0; irq_deleg_i = '0;
    trap(5'b00000, 16'h0080, 32'h5000, PM, 0, IB | 32'd7, 32'h0008, 32'h0000, "R3 R6 M timer from U");
    ret(1, PU, 32'h5000, 32'h1800, 32'h0000, "R9 mret to U after irq");
    irq_deleg_i = 16'h0020;
    trap(5'b00001, 16'h0020, 32'h5100, PS, 1, IB | 32'd5, 32'h0100, 32'h0000, "R5 R7 S timer beats illegal");
    ret(0, PU, 32'h5100, 32'h0100, 32'h0000, "R10 sret to U after irq");
    irq_deleg_i = '0;
    trap(5'b00000, 16'h0888, 32'h6000, PM, 0, IB | 32'd11, 32'h0, 32'h0, "R7 external first");
    ret(1, PU, 32'h6000, 32'h0, 32'h0, "R9 return");
    trap(5'b00000, 16'h0088, 32'h6100, PM, 0, IB | 32'd3, 32'h0, 32'h0, "R7 software before timer");
    ret(1, PU, 32'h6100, 32'h0, 32'h0, "R9 return");
    trap(5'b00000, 16'h00A0, 32'h6200, PM, 0, IB | 32'd7, 32'h0, 32'h0, "R5 R7 M timer before S timer");
    ret(1, PU, 32'h6200, 32'h0, 32'h0, "R9 return");

    trap(5'b00100, '0, 32'h7000, PM, 0, 32'd8, 32'h1888, 32'h0000, "R2 ecall from U to M");
    idle(16'h0080, 0, 0, PM, 32'd8, "R6 M timer held off by MIE=0");
    wr_status(32'h0000_0008, 32'h0000_0008, "R11 write MIE");
    irq_en_i = '0;
    idle(16'h0080, 0, 0, PM, 32'd8, "R6 M timer held off by enable mask");
    irq_en_i = 16'hFFFF;
    trap(5'b00000, 16'h0080, 32'h7100, PM, 0, IB | 32'd7, 32'h1888, 32'h1880, "R6 R8 M timer in M");
    ret(1, PM, 32'h7100, 32'h1888, 32'h0088, "R9 mret restores MIE");
    irq_deleg_i = 16'h0020;
    idle(16'h0020, 0, 0, PM, IB | 32'd7, "R6 S timer never taken in M");
    wr_status(32'h0000_1000, 32'h0000_0000, "R11 MPP 10 stored as U");
    wr_status(32'h0000_0800, 32'h0000_0800, "R11 write MPP=S");
    ret(1, PS, 32'h7100, 32'h1800, 32'h0000, "R9 mret to S");
    idle(16'h0020, 0, 0, PS, IB | 32'd7, "R6 S timer held off by SIE=0");
    wr_status(32'h0000_0002, 32'h0000_0002, "R11 write SIE");
    trap(5'b00000, 16'h0020, 32'h7200, PS, 1, IB | 32'd5, 32'h0122, 32'h0120, "R6 R8 S timer in S");
    ret(0, PS, 32'h7200, 32'h0122, 32'h0022, "R10 sret restores SIE");
    idle(16'h0000, 1, 0, PS, IB | 32'd7, "R9 mret ignored in S");

    repeat (3) @(negedge clk);
    check("R8 all redirects seen", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule